// File: doc/BRIEF.md
# Key-Guarded Serial Register Bank with Mirror Check

This block is the peripheral end of a serial register interface for a 10-bit measurement front end. A host talks to it over a four-wire SPI slave port. Every frame is 16 bits long and is shifted least significant bit first. The block keeps a small bank of settings: fault enables, lower and upper thresholds, three inrush settings, a configuration word, an enable word and an action word. It also holds the latest conversion result and a filtered result, which arrive on parallel ports with update strobes.

Register writes are refused until an unlock key has been stored in a dedicated key register. Each of the eight settings registers has a mirror copy 0x10 above it. A memory-validation fault stays raised until every mirror copy has been written and matches its primary. The fault appears as a bit in the read-only flag word and on an output port.

SCLK, chip select and MOSI are brought into the system clock domain by synchronisers. Shifting is done on the SCLK edges detected there. A read takes two frames. The first frame names the address. The second frame, sent after chip select has been released and asserted again, carries the register contents back.

Top module: `keyed_spi_regs`

## Requirements
- R1: A frame is 16 bits shifted LSB first on MOSI and MISO, with MOSI sampled on rising SCLK and MISO changed on falling SCLK. Rebuilt MSB first, bits 15:11 are the address, bit 10 is the write flag (1 = write) and bits 9:0 are the data.
- R2: A frame with the write flag clear stores its address as pending. The next frame returns that register in bits 9:0 with bits 15:10 zero. The value is captured when that frame's chip select falls and does not change while the frame shifts out.
- R3: The key register at 0x0C can always be written and can be read back. Writes to every other address are ignored unless the key register holds 0x294. Any other key value locks writes again.
- R4: The result register 0x00 loads `sample_in` only on cycles where `sample_stb` is high. The filtered register 0x01 loads `filt_in` only on cycles where `filt_stb` is high. Registers 0x00, 0x01 and the flag word 0x02 ignore SPI writes.
- R5: When unlocked, the settings registers 0x03–0x0A, the action register 0x0B and the mirror registers 0x13–0x1A take the written data and return it on reads.
- R6: The memory-validation fault (`mv_fault`, also bit 0 of the flag word 0x02) is high whenever any mirror copy has not been written since reset or differs from its primary. It is low once all eight copies match.
- R7: `ext_ref_sel` follows bit 5 of the configuration register 0x09.
- R8: A frame whose chip select is released before 16 rising SCLK edges writes nothing and stores no pending address.
- R9: A frame that has no pending read address returns all zeros. Reads of unmapped addresses also return zero.
- R10: After reset all registers hold zero, `mv_fault` is high, `ext_ref_sel` is low and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, low while deselected |
| sample_in | input | 10 | Latest conversion result |
| sample_stb | input | 1 | Loads `sample_in` into register 0x00 |
| filt_in | input | 10 | Filtered result |
| filt_stb | input | 1 | Loads `filt_in` into register 0x01 |
| ext_ref_sel | output | 1 | External reference select (configuration bit 5) |
| mv_fault | output | 1 | Memory-validation fault |

## Verification
A sample strobe can arrive while a read-back word is already shifting out. Because of this, the update of register 0x00 and its serial return can overlap. The bench forces this case: it pulses `sample_stb` with a new value in the middle of the response frame. It then requires the frame to return the value held when chip select fell, and the read that follows to return the new value. A write to a primary or mirror register also changes `mv_fault` in the same cycle as the write commits. After every random operation the bench compares the fault output with a fault value that it computes from its own shadow of all sixteen registers.

// File: rtl/keyed_spi_regs.sv
module keyed_spi_regs #(
  parameter int DW      = 10,
  parameter int AW      = 5,
  parameter int SYNC    = 2,
  parameter int NSET    = 8,
  parameter int SET0    = 3,
  parameter int MIR_OFS = 16,
  parameter int KEY     = 'h294,
  parameter int REF_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  input  logic [DW-1:0] sample_in,
  input  logic          sample_stb,
  input  logic [DW-1:0] filt_in,
  input  logic          filt_stb,
  output logic          ext_ref_sel,
  output logic          mv_fault
);
  localparam int FW     = AW + 1 + DW;
  localparam int CW     = $clog2(FW + 1);
  localparam int A_RES  = 0;
  localparam int A_FILT = 1;
  localparam int A_FLAG = 2;
  localparam int A_ACT  = SET0 + NSET;
  localparam int A_KEY  = A_ACT + 1;
  localparam int A_CFG  = SET0 + 6;

  logic [SYNC:0] sck_p, cs_p, mo_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= '0;
      cs_p  <= '1;
      mo_p  <= '0;
    end else begin
      sck_p <= {sck_p[SYNC-1:0], spi_sclk};
      cs_p  <= {cs_p[SYNC-1:0], spi_cs_n};
      mo_p  <= {mo_p[SYNC-1:0], spi_mosi};
    end

  wire sel     = ~cs_p[SYNC-1];
  wire cs_fall = cs_p[SYNC] & ~cs_p[SYNC-1];
  wire sk_rise = sel & ~sck_p[SYNC] & sck_p[SYNC-1];
  wire sk_fall = sel & sck_p[SYNC] & ~sck_p[SYNC-1];
  wire mo      = mo_p[SYNC-1];

  logic [CW-1:0] cnt;
  logic [FW-1:0] rx, tx;
  logic          pend_v;
  logic [AW-1:0] pend_a;
  logic [DW-1:0] rd_val;

  wire [FW-1:0] word = {mo, rx[FW-1:1]};
  wire          done = sk_rise & (cnt == CW'(FW - 1));
  wire          wr   = done & word[DW];
  wire [AW-1:0] wa   = word[FW-1:DW+1];
  wire [DW-1:0] wd   = word[DW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= '0;
      rx     <= '0;
      tx     <= '0;
      pend_v <= 1'b0;
      pend_a <= '0;
    end else if (cs_fall) begin
      cnt    <= '0;
      tx     <= pend_v ? {{(FW-DW){1'b0}}, rd_val} : '0;
      pend_v <= 1'b0;
    end else begin
      if (sk_rise && cnt < CW'(FW)) begin
        rx  <= word;
        cnt <= cnt + 1'b1;
      end
      if (sk_fall) tx <= tx >> 1;
      if (done && !word[DW]) begin
        pend_v <= 1'b1;
        pend_a <= wa;
      end
    end

  assign spi_miso = sel & tx[0];

  logic [DW-1:0] res_q, filt_q, act_q, key_q;
  logic [DW-1:0] set_q [NSET];
  logic [DW-1:0] mir_q [NSET];
  logic [NSET-1:0] mir_ok, miss;

  wire unlocked = (key_q == DW'(KEY));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      res_q  <= '0;
      filt_q <= '0;
      act_q  <= '0;
      key_q  <= '0;
    end else begin
      if (sample_stb) res_q <= sample_in;
      if (filt_stb) filt_q <= filt_in;
      if (wr && wa == AW'(A_KEY)) key_q <= wd;
      if (wr && unlocked && wa == AW'(A_ACT)) act_q <= wd;
    end

  for (genvar i = 0; i < NSET; i++) begin : g_set
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        set_q[i]  <= '0;
        mir_q[i]  <= '0;
        mir_ok[i] <= 1'b0;
      end else if (wr && unlocked) begin
        if (wa == AW'(SET0 + i)) set_q[i] <= wd;
        if (wa == AW'(SET0 + MIR_OFS + i)) begin
          mir_q[i]  <= wd;
          mir_ok[i] <= 1'b1;
        end
      end
    assign miss[i] = ~mir_ok[i] | (set_q[i] != mir_q[i]);
  end

  assign mv_fault    = |miss;
  assign ext_ref_sel = set_q[A_CFG-SET0][REF_BIT];

  always_comb begin
    rd_val = '0;
    case (pend_a)
      AW'(A_RES):  rd_val = res_q;
      AW'(A_FILT): rd_val = filt_q;
      AW'(A_FLAG): rd_val = {{(DW-1){1'b0}}, mv_fault};
      AW'(A_ACT):  rd_val = act_q;
      AW'(A_KEY):  rd_val = key_q;
      default: ;
    endcase
    for (int i = 0; i < NSET; i++) begin
      if (pend_a == AW'(SET0 + i)) rd_val = set_q[i];
      if (pend_a == AW'(SET0 + MIR_OFS + i)) rd_val = mir_q[i];
    end
  end
endmodule

// File: rtl/keyed_spi_regs_chk.sv
module keyed_spi_regs_chk #(
  parameter int DW  = 10,
  parameter int KEY = 'h294
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample_stb,
  input logic [DW-1:0] res_q,
  input logic [DW-1:0] cfg_q,
  input logic [DW-1:0] key_q,
  input logic          done,
  input logic          pend_v,
  input logic          mv_fault
);
  assert_res_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_q) |-> $past(sample_stb));

  assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(key_q) == DW'(KEY));

  assert_fault_after_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> mv_fault);

  assert_key_full_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(key_q) |-> $past(done));

  assert_pending_from_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_v) |-> $past(done));
endmodule

bind keyed_spi_regs keyed_spi_regs_chk #(.DW(DW), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .res_q(res_q),
  .cfg_q(set_q[A_CFG-SET0]), .key_q(key_q), .done(done), .pend_v(pend_v),
  .mv_fault(mv_fault)
);

// File: tb/keyed_spi_regs_tb.sv
module keyed_spi_regs_tb;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, cs_n = 1, mosi = 0;
  logic miso, ext_ref, fault;
  logic [9:0] s_in = 0, f_in = 0;
  logic s_stb = 0, f_stb = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  keyed_spi_regs u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .sample_in(s_in), .sample_stb(s_stb), .filt_in(f_in),
    .filt_stb(f_stb), .ext_ref_sel(ext_ref), .mv_fault(fault)
  );

  logic [9:0] mdl [32];
  bit mok [8];

  function automatic bit exp_fault();
    for (int i = 0; i < 8; i++)
      if (!mok[i] || mdl[3+i] != mdl[16+3+i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [15:0] exp_rd(input int a);
    if (a == 2) return {15'b0, exp_fault()};
    if (a <= 12 || (a >= 19 && a <= 26)) return {6'b0, mdl[a]};
    return 16'h0;
  endfunction

  function automatic void m_write(input int a, input logic [9:0] d);
    if (a == 12) mdl[12] = d;
    else if (mdl[12] == 10'h294) begin
      if (a >= 3 && a <= 11) mdl[a] = d;
      if (a >= 19 && a <= 26) begin mdl[a] = d; mok[a-19] = 1; end
    end
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] w, input int nb, input bit mid,
                      input logic [9:0] mv, output logic [15:0] r);
    r = 16'h0;
    cs_n = 0;
    wait_n(8);
    for (int i = 0; i < nb; i++) begin
      mosi = w[i];
      wait_n(6);
      r[i] = miso;
      if (mid && i == 8) begin
        s_in = mv; s_stb = 1; wait_n(1); s_stb = 0;
        mdl[0] = mv;
      end
      sclk = 1;
      wait_n(6);
      sclk = 0;
    end
    wait_n(8);
    cs_n = 1;
    wait_n(8);
  endtask

  task automatic wr(input int a, input logic [9:0] d);
    logic [15:0] r;
    xfer({a[4:0], 1'b1, d}, 16, 0, 0, r);
    m_write(a, d);
  endtask

  task automatic rd(input int a, output logic [15:0] r);
    logic [15:0] t;
    xfer({a[4:0], 1'b0, 10'h0}, 16, 0, 0, t);
    xfer({5'h1f, 1'b1, 10'h0}, 16, 0, 0, r);
  endtask

  task automatic rd_chk(input string req, input int a);
    logic [15:0] r;
    rd(a, r);
    chk(req, r, exp_rd(a));
  endtask

  task automatic strobe(input bit which, input logic [9:0] v);
    if (which) begin f_in = v; f_stb = 1; mdl[1] = v; end
    else begin s_in = v; s_stb = 1; mdl[0] = v; end
    wait_n(1);
    s_stb = 0; f_stb = 0;
    wait_n(2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    int unsigned seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < 32; i++) mdl[i] = 0;
    for (int i = 0; i < 8; i++) mok[i] = 0;
    wait_n(5);
    rst_n = 1;
    wait_n(4);

    chk("R10 miso", {15'b0, miso}, 16'h0);
    chk("R10 fault", {15'b0, fault}, 16'h1);
    chk("R10 ext_ref", {15'b0, ext_ref}, 16'h0);
    rd_chk("R10 key reset", 12);
    rd_chk("R6 flag bit", 2);

    wr(9, 10'h020);
    rd_chk("R3 locked write", 9);
    chk("R3 ext_ref locked", {15'b0, ext_ref}, 16'h0);

    wr(12, 10'h294);
    rd_chk("R3 key readback", 12);
    wr(9, 10'h3df);
    rd_chk("R5 cfg write", 9);
    chk("R7 ext_ref clear", {15'b0, ext_ref}, 16'h0);
    wr(9, 10'h020);
    chk("R7 ext_ref set", {15'b0, ext_ref}, 16'h1);
    wr(11, 10'h2a5);
    rd_chk("R5 act write", 11);

    wr(0, 10'h155);
    wr(1, 10'h0f0);
    wr(2, 10'h3ff);
    rd_chk("R4 result ignores spi", 0);
    rd_chk("R4 flags ignore spi", 2);
    strobe(0, 10'h2ab);
    strobe(1, 10'h111);
    s_in = 10'h3c3; f_in = 10'h0aa;
    wait_n(3);
    rd_chk("R4 result strobed", 0);
    rd_chk("R4 filt strobed", 1);

    xfer({5'd4, 1'b1, 10'h0aa}, 10, 0, 0, r);
    rd_chk("R8 truncated write", 4);
    xfer({5'd9, 1'b0, 10'h0}, 16, 0, 0, r);
    xfer({5'h1f, 1'b1, 10'h0}, 7, 0, 0, r);
    xfer({5'h1f, 1'b1, 10'h0}, 16, 0, 0, r);
    chk("R8 R9 pending consumed", r, 16'h0);
    xfer({5'h1f, 1'b1, 10'h0}, 16, 0, 0, r);
    chk("R9 no pending", r, 16'h0);
    rd_chk("R9 unmapped", 14);

    for (int i = 0; i < 8; i++) wr(19 + i, mdl[3+i]);
    chk("R6 all mirrors match", {15'b0, fault}, 16'h0);
    rd_chk("R6 flag clear", 2);
    wr(5, 10'h123);
    chk("R6 mismatch", {15'b0, fault}, 16'h1);
    wr(21, 10'h123);
    chk("R6 rematch", {15'b0, fault}, 16'h0);
    rd_chk("R5 mirror read", 21);

    wr(12, 10'h000);
    wr(4, 10'h0cc);
    wr(20, 10'h0cc);
    rd_chk("R3 relocked", 4);
    rd_chk("R3 relocked mirror", 20);
    wr(12, 10'h293);
    wr(4, 10'h0cc);
    rd_chk("R3 wrong key", 4);

    xfer({5'd0, 1'b0, 10'h0}, 16, 0, 0, r);
    begin
      logic [15:0] e;
      e = exp_rd(0);
      xfer({5'h1f, 1'b1, 10'h0}, 16, 1, 10'h1e7, r);
      chk("R2 value held through frame", r, e);
    end
    rd_chk("R2 new value next read", 0);
    xfer({5'd1, 1'b0, 10'h0}, 16, 0, 0, r);
    xfer({5'd2, 1'b0, 10'h0}, 16, 0, 0, r);
    chk("R1 R2 back-to-back read", r, exp_rd(1));
    xfer({5'h1f, 1'b1, 10'h0}, 16, 0, 0, r);
    chk("R1 R2 back-to-back flags", r, exp_rd(2));

    for (int n = 0; n < 110; n++) begin
      int op, a;
      logic [9:0] d;
      op = $urandom % 8;
      a = $urandom % 32;
      d = 10'($urandom);
      case (op)
        0: wr(12, 10'h294);
        1: wr(12, d);
        2, 3: wr(a, d);
        4: strobe(d[0], d);
        default: rd_chk("R5 random read", a);
      endcase
      chk("R6 random fault", {15'b0, fault}, {15'b0, exp_fault()});
      chk("R7 random ext_ref", {15'b0, ext_ref}, {15'b0, mdl[9][5]});
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule